// File: doc/BRIEF.md
# Serial Management Register Access Engine

This block takes a register request from a CPU-side register file and runs it as one or more frames on a serial management bus: a divided management clock, a frame-valid strobe, and one data line that is driven by the engine or released to the addressed slave. A request is either a single write, a single read, or a block statistics read. A block read walks seven consecutive register addresses of one device and leaves the seven values in seven result words.

Software starts a request by pulsing the start input, which is the hardware form of writing 1 to a go bit. The busy output reads back as that bit and drops when the request completes. On every read frame the engine checks that the slave drives a 0 in the last turnaround bit. If the slave fails this check, the request is flagged as an invalid read. Completion and read error each feed the single interrupt line through their own enable.

Top module: `mdio_rd_engine`

## Requirements
- R1: A cmdStart pulse while idle is accepted: busy reads 1 on the following cycle and returns to 0 on the cycle the last frame of the request is finished.
- R2: Every frame has 32 bits, sent MSB first and sampled by the slave on the rising management clock. The fields are start 01, opcode (10 read, 01 write), 5-bit device, 5-bit register, 2 turnaround bits and 16 data bits. A write drives turnaround 10 followed by the write data.
- R3: mdc idles low and runs at the system clock divided by 2*HALF_DIV while busy. mdValid and mdOut change only on a falling edge of mdc, or at the start of a request while mdc is low.
- R4: mdOe is 1 only inside a frame. A read releases the line (mdOe=0) from the first turnaround bit to the end of the frame. A write drives all 32 bits.
- R5: On each read frame the engine samples mdIn at the rising edge of the second turnaround bit. If it sees 1 in any frame of the request, rdErr is 1 after completion.
- R6: A single read stores its 16 data bits in result word 0 and leaves the other words unchanged. A write changes no result word.
- R7: A block read runs 7 frames to register addresses reg, reg+1, ... reg+6, wrapping modulo 32, and stores frame i in result word i. Between frames mdValid is low for one mdc period.
- R8: A cmdStart pulse while busy is ignored. No frame is added and the running request's fields and results are unaffected.
- R9: irq = (done & ieDone) | (rdErr & ieErr), where done is set on completion. intClr clears done and rdErr, and so does the acceptance of a new request.
- R10: After reset, busy, mdc, mdValid, mdOe, irq and rdErr are 0 and all result words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | One-cycle request pulse (go bit write) |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdBlock | input | 1 | 1 = seven-register block read (forces read) |
| cmdDev | input | 5 | Device address |
| cmdReg | input | 5 | Register address (first address for a block read) |
| cmdWrData | input | 16 | Data for a write |
| ieDone | input | 1 | Enable for the completion interrupt |
| ieErr | input | 1 | Enable for the read error interrupt |
| intClr | input | 1 | Clears the completion and error status |
| busy | output | 1 | Request in progress (go bit readback) |
| result | output | 7x16 | Result words, word i = frame i of a read |
| rdErr | output | 1 | Last request saw a missing leading zero |
| irq | output | 1 | Interrupt request |
| mdc | output | 1 | Management clock |
| mdValid | output | 1 | Frame-valid strobe |
| mdOut | output | 1 | Serial data driven by the engine |
| mdOe | output | 1 | 1 = engine drives the data line |
| mdIn | input | 1 | Serial data seen on the line |

## Verification
A bit counter or word counter that is off by one shows at the ports within one frame. The slave model then decodes a shifted device or register field, a block read lands in the wrong result word, or the frame count after completion differs from the expected count. A wrong turnaround sample position either raises rdErr when the slave drives 0, or misses a planted 1, and this is seen when busy drops. Divider or edge-placement faults show as a wrong mdc period or a wrong inter-frame gap on the first frame after the start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 32;
  localparam int DRIVE_BITS = 14;               // bits driven on a read
  localparam int TA_LAST    = 15;               // second turnaround bit
  localparam int DATA_LO    = 16;
  localparam int FRAME_LAST = FRAME_BITS - 1;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic load;
    logic shift;
    logic nextFrame;
    logic sampleTa;
    logic sampleData;
    logic storeWord;
    logic finish;
  } mdioStb_t;

  function automatic logic [FRAME_BITS-1:0] buildFrame(
      input logic rd, input logic [ADDR_W-1:0] dev,
      input logic [ADDR_W-1:0] regA, input logic [DATA_W-1:0] wd);
    return {2'b01, (rd ? 2'b10 : 2'b01), dev, regA,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : wd)};
  endfunction
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int BLOCK_WORDS = 7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     cmdRead,
  input  logic     cmdBlock,
  output logic     busy,
  output logic     mdc,
  output logic     mdValid,
  output logic     mdOe,
  output mdioStb_t stb
);
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int WORD_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

  logic              runQ, mdcQ, validQ, readQ;
  logic [DIV_W-1:0]  divQ;
  logic [BIT_W-1:0]  bitQ;
  logic [WORD_W-1:0] wordQ, lastQ;
  logic              tick, rise, fall;

  assign tick = runQ && (divQ == DIV_W'(HALF_DIV - 1));
  assign rise = tick && !mdcQ;
  assign fall = tick && mdcQ;

  always_comb begin
    stb      = '0;
    stb.load = !runQ && cmdStart;
    if (rise && readQ) begin
      stb.sampleTa   = (bitQ == BIT_W'(TA_LAST));
      stb.sampleData = (bitQ >= BIT_W'(DATA_LO)) && (bitQ <= BIT_W'(FRAME_LAST));
    end
    if (fall) begin
      if (bitQ < BIT_W'(FRAME_LAST))       stb.shift     = 1'b1;
      else if (bitQ == BIT_W'(FRAME_LAST)) stb.storeWord = readQ;
      else if (wordQ == lastQ)             stb.finish    = 1'b1;
      else                                 stb.nextFrame = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0; mdcQ <= 1'b0; validQ <= 1'b0; readQ <= 1'b0;
      divQ <= '0; bitQ <= '0; wordQ <= '0; lastQ <= '0;
    end else if (stb.load) begin
      runQ   <= 1'b1;
      divQ   <= '0;
      mdcQ   <= 1'b0;
      validQ <= 1'b1;
      bitQ   <= '0;
      wordQ  <= '0;
      readQ  <= cmdRead || cmdBlock;
      lastQ  <= cmdBlock ? WORD_W'(BLOCK_WORDS - 1) : '0;
    end else if (runQ) begin
      divQ <= tick ? '0 : divQ + 1'b1;
      if (tick) mdcQ <= !mdcQ;
      if (stb.shift) bitQ <= bitQ + 1'b1;
      if (fall && bitQ == BIT_W'(FRAME_LAST)) begin
        bitQ   <= BIT_W'(FRAME_BITS);       // one idle bit between frames
        validQ <= 1'b0;
      end
      if (stb.nextFrame) begin
        bitQ   <= '0;
        wordQ  <= wordQ + 1'b1;
        validQ <= 1'b1;
      end
      if (stb.finish) runQ <= 1'b0;
    end
  end

  assign busy    = runQ;
  assign mdc     = mdcQ;
  assign mdValid = validQ;
  assign mdOe    = validQ && (!readQ || bitQ < BIT_W'(DRIVE_BITS));

  // R3
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdValid != $past(mdValid)) |-> !mdc);
  // R3
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R4
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdOe |-> mdValid);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int BLOCK_WORDS = 7
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  mdioStb_t                            stb,
  input  logic                                busy,
  input  logic                                cmdStart,
  input  logic                                cmdRead,
  input  logic                                cmdBlock,
  input  logic [ADDR_W-1:0]                   cmdDev,
  input  logic [ADDR_W-1:0]                   cmdReg,
  input  logic [DATA_W-1:0]                   cmdWrData,
  input  logic                                mdIn,
  input  logic                                intClr,
  input  logic                                ieDone,
  input  logic                                ieErr,
  output logic                                mdOut,
  output logic [BLOCK_WORDS-1:0][DATA_W-1:0]  result,
  output logic                                rdErr,
  output logic                                irq
);
  localparam int WORD_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

  logic [ADDR_W-1:0]                  devQ, regQ;
  logic [DATA_W-1:0]                  wrQ, rxQ;
  logic                               readQ, taBadQ, doneQ, errQ;
  logic [WORD_W-1:0]                  offQ;
  logic [FRAME_BITS-1:0]              txQ;
  logic [BLOCK_WORDS-1:0][DATA_W-1:0] resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devQ <= '0; regQ <= '0; wrQ <= '0; rxQ <= '0; readQ <= 1'b0;
      taBadQ <= 1'b0; offQ <= '0; txQ <= '0; resQ <= '0;
    end else begin
      if (stb.load) begin
        devQ   <= cmdDev;
        regQ   <= cmdReg;
        wrQ    <= cmdWrData;
        readQ  <= cmdRead || cmdBlock;
        offQ   <= '0;
        taBadQ <= 1'b0;
        txQ    <= buildFrame(cmdRead || cmdBlock, cmdDev, cmdReg, cmdWrData);
      end
      if (stb.nextFrame) begin
        offQ <= offQ + 1'b1;
        txQ  <= buildFrame(readQ, devQ, regQ + ADDR_W'(offQ + 1'b1), wrQ);
      end
      if (stb.shift)      txQ    <= {txQ[FRAME_BITS-2:0], 1'b1};
      if (stb.sampleTa)   taBadQ <= taBadQ | mdIn;
      if (stb.sampleData) rxQ    <= {rxQ[DATA_W-2:0], mdIn};
      if (stb.storeWord)  resQ[offQ] <= rxQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0; errQ <= 1'b0;
    end else if (stb.load) begin
      doneQ <= 1'b0; errQ <= 1'b0;
    end else if (stb.finish) begin
      doneQ <= 1'b1; errQ <= taBadQ;
    end else if (intClr) begin
      doneQ <= 1'b0; errQ <= 1'b0;
    end
  end

  assign mdOut  = txQ[FRAME_BITS-1];
  assign result = resQ;
  assign rdErr  = errQ;
  assign irq    = (doneQ && ieDone) || (errQ && ieErr);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdStart) |=> ($stable(devQ) && $stable(regQ)));
  // R1
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneQ);
  // R5
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $fell(busy));
endmodule

// File: rtl/mdio_rd_engine.sv
module mdio_rd_engine
  import mdio_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int BLOCK_WORDS = 7
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cmdStart,
  input  logic                                cmdRead,
  input  logic                                cmdBlock,
  input  logic [4:0]                          cmdDev,
  input  logic [4:0]                          cmdReg,
  input  logic [15:0]                         cmdWrData,
  input  logic                                ieDone,
  input  logic                                ieErr,
  input  logic                                intClr,
  output logic                                busy,
  output logic [BLOCK_WORDS-1:0][15:0]        result,
  output logic                                rdErr,
  output logic                                irq,
  output logic                                mdc,
  output logic                                mdValid,
  output logic                                mdOut,
  output logic                                mdOe,
  input  logic                                mdIn
);
  mdioStb_t stb;

  mdio_ctrl #(.HALF_DIV(HALF_DIV), .BLOCK_WORDS(BLOCK_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cmdBlock(cmdBlock), .busy(busy), .mdc(mdc), .mdValid(mdValid),
    .mdOe(mdOe), .stb(stb));

  mdio_dp #(.BLOCK_WORDS(BLOCK_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .cmdStart(cmdStart),
    .cmdRead(cmdRead), .cmdBlock(cmdBlock), .cmdDev(cmdDev),
    .cmdReg(cmdReg), .cmdWrData(cmdWrData), .mdIn(mdIn), .intClr(intClr),
    .ieDone(ieDone), .ieErr(ieErr), .mdOut(mdOut), .result(result),
    .rdErr(rdErr), .irq(irq));
endmodule

// File: tb/tb_mdio_rd_engine.sv
module tb_mdio_rd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int WORDS = 7;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 0, cmdRead = 0, cmdBlock = 0, ieDone = 0, ieErr = 0, intClr = 0;
  logic [4:0] cmdDev = 0, cmdReg = 0;
  logic [15:0] cmdWrData = 0;
  logic busy, rdErr, irq, mdc, mdValid, mdOut, mdOe;
  logic mdIn = 1'b1;
  logic [WORDS-1:0][15:0] result;

  int nChecks = 0, nFails = 0;

  mdio_rd_engine #(.HALF_DIV(HALF), .BLOCK_WORDS(WORDS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] slaveWord(input logic [4:0] d, input logic [4:0] r);
    return {d, r, 6'(d ^ r)} ^ 16'h5A3C;
  endfunction

  // slave model state
  logic        sRead = 0;
  logic [4:0]  sDev = 0, sReg = 0;
  logic [15:0] sWd = 0;
  int          sBadFrame = -1, sFrameIdx = 0, sBitCnt = 0, frameCount = 0;
  logic [31:0] sBits = 0;
  time         tFall = 0;

  always @(posedge mdc) begin
    if (mdValid) begin
      automatic int c = sBitCnt;
      automatic logic [4:0] rExp = sReg + 5'(sFrameIdx);
      sBits = {sBits[30:0], mdOut};
      if (c == 13) begin
        chk("R2 start", 32'(sBits[13:12]), 32'd1);
        chk("R2 opcode", 32'(sBits[11:10]), sRead ? 32'd2 : 32'd1);
        chk("R2 device", 32'(sBits[9:5]), 32'(sDev));
        chk("R7 register", 32'(sBits[4:0]), 32'(rExp));
      end
      if (c == 14) chk("R4 drive at turnaround", 32'(mdOe), sRead ? 32'd0 : 32'd1);
      if (c == 31 && !sRead) chk("R2 write ta+data", 32'(sBits[17:0]), 32'({2'b10, sWd}));
      sBitCnt = c + 1;
      if (sRead) begin
        #1;
        if (c == 14) mdIn = (sFrameIdx == sBadFrame);
        else if (c >= 15 && c <= 30) mdIn = slaveWord(sDev, rExp)[30 - c];
        else mdIn = 1'b1;
      end
    end
  end

  always @(negedge mdValid) begin
    if (rstN) begin
      frameCount++; sFrameIdx++; sBitCnt = 0; mdIn = 1'b1; tFall = $time;
    end
  end

  always @(posedge mdValid) begin
    // R7 one idle mdc period between frames
    if (sFrameIdx > 0) chk("R7 gap", 32'($time - tFall), 32'(2*HALF*CLK_PERIOD));
  end

  // scoreboard
  typedef struct {
    logic [WORDS-1:0][15:0] res;
    logic err;
    logic irqE;
    int frames;
    int base;
  } exp_t;
  exp_t q[$];
  logic [WORDS-1:0][15:0] model = '0;

  always begin
    @(negedge busy);
    @(negedge clk);
    if (q.size() == 0) chk("R8 unexpected completion", 32'd1, 32'd0);
    else begin
      automatic exp_t e = q.pop_front();
      for (int i = 0; i < WORDS; i++) chk("R6 R7 result", 32'(result[i]), 32'(e.res[i]));
      chk("R5 rdErr", 32'(rdErr), 32'(e.err));
      chk("R9 irq", 32'(irq), 32'(e.irqE));
      chk("R7 frame count", 32'(frameCount - e.base), 32'(e.frames));
    end
  end

  task automatic issue(input logic rd, input logic blk, input logic [4:0] d,
                       input logic [4:0] r, input logic [15:0] wd, input int bad);
    exp_t e;
    int n = blk ? WORDS : 1;
    logic anyBad = (rd || blk) && bad >= 0 && bad < n;
    @(negedge clk);
    sRead = rd || blk; sDev = d; sReg = r; sWd = wd; sBadFrame = bad; sFrameIdx = 0;
    if (blk) for (int i = 0; i < WORDS; i++) model[i] = slaveWord(d, r + 5'(i));
    else if (rd) model[0] = slaveWord(d, r);
    e.res = model; e.err = anyBad; e.irqE = ieDone || (anyBad && ieErr);
    e.frames = n; e.base = frameCount;
    q.push_back(e);
    cmdRead = rd; cmdBlock = blk; cmdDev = d; cmdReg = r; cmdWrData = wd; cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    chk("R1 busy after start", 32'(busy), 32'd1);
    chk("R9 status cleared by start", 32'({rdErr, irq}), 32'd0);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", 32'({busy, mdc, mdValid, mdOe, irq, rdErr}), 32'd0);
    for (int i = 0; i < WORDS; i++) chk("R10 reset result", 32'(result[i]), 32'd0);
    rstN = 1;
    @(negedge clk);
    ieDone = 1; ieErr = 1;

    // single read, with clock period check (R3)
    issue(1, 0, 5'd3, 5'd5, 16'h0, -1);
    begin
      time t0;
      @(posedge mdc); t0 = $time;
      @(posedge mdc);
      chk("R3 mdc period", 32'($time - t0), 32'(2*HALF*CLK_PERIOD));
    end
    waitIdle();

    // R9 interrupt clear
    @(negedge clk); intClr = 1; @(negedge clk); intClr = 0;
    chk("R9 irq after clear", 32'(irq), 32'd0);

    // write leaves results unchanged (R6)
    issue(0, 0, 5'd7, 5'd9, 16'hBEEF, -1);
    waitIdle();

    // block read with address wrap (R7)
    issue(0, 1, 5'd1, 5'd28, 16'h0, -1);
    waitIdle();

    // single read after block keeps words 1..6 (R6)
    issue(1, 0, 5'd12, 5'd0, 16'h0, -1);
    waitIdle();

    // missing leading zero with both enables off (R5, R9)
    ieDone = 0; ieErr = 0;
    issue(1, 0, 5'd4, 5'd17, 16'h0, 0);
    waitIdle();
    ieErr = 1;
    @(negedge clk);
    chk("R9 error enable raises irq", 32'(irq), 32'd1);

    // block read with one bad frame (R5)
    ieErr = 0;
    issue(1, 1, 5'd30, 5'd2, 16'h0, 4);
    waitIdle();

    // start while busy ignored (R8)
    ieDone = 1;
    issue(1, 0, 5'd9, 5'd21, 16'h0, -1);
    repeat (20) @(negedge clk);
    cmdDev = 5'd31; cmdReg = 5'd31; cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    waitIdle();
    repeat (3) @(negedge clk);
    chk("R8 no second request", 32'(busy), 32'd0);

    repeat (5) @(negedge clk);
    chk("R1 scoreboard drained", 32'(q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule